// File: doc/BRIEF.md
# Second-Operand Barrel Shifter

This block forms the second operand of a 32-bit load-store processor's ALU, and the carry that the shifter hands to the flags. It works in one of two ways. In the first, an 8-bit constant from the instruction is rotated right by twice a 4-bit rotate field. In the second, a source register value is shifted. The shift kind comes from a 2-bit field. The shift count comes either from a 5-bit field in the instruction or from the low byte of a second register.

The block is purely combinational and sits between the register read ports and the ALU. The decoder presents the fields, and the block returns the operand and the shifter carry in the same cycle. The flag register, the ALU and all other instruction decoding belong to neighbouring blocks.

Top module: `opsh_operand_unit`

## Requirements
- R1: With `use_imm`=1, `operand_out` equals `imm_byte`, zero-extended to 32 bits and rotated right by 2×`imm_rot` positions.
- R2: With `use_imm`=1, `carry_out` equals `carry_in` when `imm_rot`=0, and equals bit 31 of `operand_out` otherwise.
- R3: With `use_imm`=0 and `amt_from_reg`=0, `src_value` is shifted by `amt_field`. The `shift_kind` encoding is 00 logical left, 01 logical right, 10 arithmetic right (sign fill) and 11 rotate right.
- R4: For a count n in 1..31, `carry_out` is the last bit shifted out. That is `src_value[32-n]` for logical left, and `src_value[n-1]` for the three right kinds.
- R5: A count of zero, whether from the field or from a register low byte of 0, gives `operand_out`=`src_value` and `carry_out`=`carry_in` for every shift kind.
- R6: With `amt_from_reg`=1, the count is `amt_reg[7:0]`. Bits 31:8 of `amt_reg` and the `amt_field` input have no effect.
- R7: A logical shift by a register count of exactly 32 gives zero, with carry `src_value[0]` for left shifts and `src_value[31]` for right shifts. A logical shift by a register count above 32 gives zero with carry 0.
- R8: An arithmetic right shift by a register count of 32 or more gives 32 copies of `src_value[31]`, and the carry equals that same bit.
- R9: A rotate right by a register count uses the count modulo 32. A nonzero count that is a multiple of 32 returns `src_value` with carry `src_value[31]`.
- R10: With `use_imm`=1, the register and shift inputs have no effect. With `use_imm`=0, `imm_byte` and `imm_rot` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| use_imm | input | 1 | 1 selects the rotated constant, 0 selects the shifted register |
| imm_byte | input | 8 | Constant value |
| imm_rot | input | 4 | Half of the constant's right-rotate distance |
| shift_kind | input | 2 | Shift kind code for the register path |
| amt_from_reg | input | 1 | 1 takes the count from `amt_reg[7:0]`, 0 takes it from `amt_field` |
| amt_field | input | 5 | Count taken from the instruction |
| src_value | input | 32 | Register value to be shifted |
| amt_reg | input | 32 | Register that holds the count in its low byte |
| carry_in | input | 1 | Current carry flag |
| operand_out | output | 32 | Second ALU operand |
| carry_out | output | 1 | Shifter carry |

## Verification
Two of the block's functions can fire on the same input: the zero-count pass-through and the rotate count taken modulo 32. A register count of 0x100 reduces to zero in both senses, while 0x40 and 0x20 reduce to zero only modulo 32. Each of these counts is applied with `carry_in` set opposite to `src_value[31]`. The carry therefore shows which rule won: `carry_in` for a low byte of zero, and bit 31 for a nonzero multiple of 32. A sweep of register counts from 0 to 70 on a rotate repeats the comparison against a rotation computed in the bench.

// File: rtl/opsh_pkg.sv
package opsh_pkg;

   typedef enum logic [1:0] {
      SH_LSL = 2'b00,
      SH_LSR = 2'b01,
      SH_ASR = 2'b10,
      SH_ROR = 2'b11
   } shift_kind_e;

   // Special-count classes resolved before the barrel.
   typedef struct packed {
      logic pass;   // count of zero
      logic full;   // count equal to the word width (or rotate wrap)
      logic over;   // count beyond the word width
   } amt_class_t;

endpackage

// File: rtl/opsh_rotr.sv
module opsh_rotr #(
   parameter int unsigned W    = 32,
   parameter int unsigned SH_W = 5
) (
   input  logic [W-1:0]    din,
   input  logic [SH_W-1:0] amt,
   output logic [W-1:0]    dout
);

   if ((1 << SH_W) > W) begin : g_bad_width
      $error("opsh_rotr: rotate span exceeds word width");
   end

   logic [W-1:0] stage [0:SH_W];

   assign stage[0] = din;

   for (genvar k = 0; k < SH_W; k++) begin : g_stage
      localparam int unsigned STEP = 1 << k;
      assign stage[k+1] = amt[k] ? {stage[k][STEP-1:0], stage[k][W-1:STEP]}
                                 : stage[k];
   end

   assign dout = stage[SH_W];

endmodule

// File: rtl/opsh_amount.sv
module opsh_amount
   import opsh_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned AMT_W  = 5,
   parameter int unsigned AREG_W = 8
) (
   input  logic              from_reg,
   input  logic [AMT_W-1:0]  field,
   input  logic [AREG_W-1:0] reg_low,
   input  shift_kind_e       kind,
   output logic [AMT_W-1:0]  n,
   output amt_class_t        cls
);

   if (AREG_W <= AMT_W) begin : g_bad_areg
      $error("opsh_amount: register count must be wider than field count");
   end

   localparam logic [AREG_W-1:0] FULL_CNT = AREG_W'(DATA_W);

   always_comb begin
      cls = '0;
      if (!from_reg) begin
         n        = field;
         cls.pass = (field == '0);
      end else begin
         n        = reg_low[AMT_W-1:0];
         cls.pass = (reg_low == '0);
         if (kind == SH_ROR) begin
            cls.full = (reg_low != '0) && (n == '0);
         end else begin
            cls.full = (reg_low == FULL_CNT);
            cls.over = (reg_low >  FULL_CNT);
         end
      end
   end

endmodule

// File: rtl/opsh_core.sv
module opsh_core
   import opsh_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned AMT_W  = 5
) (
   input  logic [DATA_W-1:0] src,
   input  shift_kind_e       kind,
   input  logic [AMT_W-1:0]  n,
   input  amt_class_t        cls,
   input  logic              carry_in,
   output logic [DATA_W-1:0] res,
   output logic              cout
);

   localparam int unsigned MSB = DATA_W - 1;

   logic [AMT_W-1:0]  rot_amt;
   logic [DATA_W-1:0] rotated;
   logic [DATA_W-1:0] lmask;
   logic [DATA_W-1:0] rmask;
   logic              sgn;

   // A left shift by n is a right rotate by (width - n) followed by a mask.
   assign rot_amt = (kind == SH_LSL) ? (AMT_W'(0) - n) : n;
   assign lmask   = {DATA_W{1'b1}} << n;
   assign rmask   = {DATA_W{1'b1}} >> n;
   assign sgn     = src[MSB];

   opsh_rotr #(.W(DATA_W), .SH_W(AMT_W)) i_rot (
      .din  (src),
      .amt  (rot_amt),
      .dout (rotated)
   );

   always_comb begin
      res  = rotated;
      cout = src[AMT_W'(n - 1'b1)];
      unique case (kind)
         SH_LSL: begin
            res  = rotated & lmask;
            cout = src[rot_amt];
         end
         SH_LSR: res = rotated & rmask;
         SH_ASR: res = (rotated & rmask) | (sgn ? ~rmask : '0);
         SH_ROR: res = rotated;
         default: res = rotated;
      endcase

      if (cls.pass) begin
         res  = src;
         cout = carry_in;
      end else if (cls.full) begin
         unique case (kind)
            SH_LSL:  begin res = '0;               cout = src[0]; end
            SH_LSR:  begin res = '0;               cout = sgn;    end
            SH_ASR:  begin res = {DATA_W{sgn}};    cout = sgn;    end
            default: begin res = src;              cout = sgn;    end
         endcase
      end else if (cls.over) begin
         if (kind == SH_ASR) begin
            res  = {DATA_W{sgn}};
            cout = sgn;
         end else begin
            res  = '0;
            cout = 1'b0;
         end
      end
   end

endmodule

// File: rtl/opsh_operand_unit.sv
module opsh_operand_unit
   import opsh_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IMM_W  = 8,
   parameter int unsigned ROT_W  = 4,
   parameter int unsigned AREG_W = 8
) (
   input  logic              use_imm,
   input  logic [7:0]        imm_byte,
   input  logic [3:0]        imm_rot,
   input  logic [1:0]        shift_kind,
   input  logic              amt_from_reg,
   input  logic [4:0]        amt_field,
   input  logic [31:0]       src_value,
   input  logic [31:0]       amt_reg,
   input  logic              carry_in,
   output logic [31:0]       operand_out,
   output logic              carry_out
);

   localparam int unsigned AMT_W = $clog2(DATA_W);
   localparam int unsigned MSB   = DATA_W - 1;

   if (DATA_W != 32 || IMM_W != 8 || ROT_W != 4 || AMT_W != 5) begin : g_bad_ports
      $error("opsh_operand_unit: port widths are fixed at the default geometry");
   end
   if ((1 << AMT_W) != DATA_W) begin : g_bad_pow2
      $error("opsh_operand_unit: DATA_W must be a power of two");
   end
   if (ROT_W + 1 > AMT_W) begin : g_bad_rot
      $error("opsh_operand_unit: doubled rotate field exceeds count width");
   end
   if (AREG_W > DATA_W) begin : g_bad_areg
      $error("opsh_operand_unit: count byte wider than the register");
   end

   // Immediate path
   logic [DATA_W-1:0] imm_val;
   logic              imm_c;

   opsh_rotr #(.W(DATA_W), .SH_W(AMT_W)) i_imm_rot (
      .din  (DATA_W'(imm_byte)),
      .amt  (AMT_W'({imm_rot, 1'b0})),
      .dout (imm_val)
   );

   assign imm_c = (imm_rot == '0) ? carry_in : imm_val[MSB];

   // Register path
   shift_kind_e       kind;
   logic [AMT_W-1:0]  cnt;
   amt_class_t        cls;
   logic [DATA_W-1:0] reg_val;
   logic              reg_c;

   assign kind = shift_kind_e'(shift_kind);

   opsh_amount #(.DATA_W(DATA_W), .AMT_W(AMT_W), .AREG_W(AREG_W)) i_amount (
      .from_reg (amt_from_reg),
      .field    (amt_field),
      .reg_low  (amt_reg[AREG_W-1:0]),
      .kind     (kind),
      .n        (cnt),
      .cls      (cls)
   );

   opsh_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) i_core (
      .src      (src_value),
      .kind     (kind),
      .n        (cnt),
      .cls      (cls),
      .carry_in (carry_in),
      .res      (reg_val),
      .cout     (reg_c)
   );

   assign operand_out = use_imm ? imm_val : reg_val;
   assign carry_out   = use_imm ? imm_c   : reg_c;

endmodule

// File: rtl/opsh_operand_chk.sv
module opsh_operand_chk #(
   parameter int unsigned DATA_W = 32
) (
   input logic              use_imm,
   input logic [7:0]        imm_byte,
   input logic [3:0]        imm_rot,
   input logic [1:0]        shift_kind,
   input logic              amt_from_reg,
   input logic [4:0]        amt_field,
   input logic [31:0]       src_value,
   input logic [31:0]       amt_reg,
   input logic              carry_in,
   input logic [31:0]       operand_out,
   input logic              carry_out
);

   localparam int unsigned MSB = DATA_W - 1;

   logic zero_cnt;
   assign zero_cnt = amt_from_reg ? (amt_reg[7:0] == 8'd0) : (amt_field == 5'd0);

   always_comb begin
      if (use_imm) begin
         assert_imm_bits_kept_R1:
            assert ($countones(operand_out) == $countones(imm_byte))
            else $error("R1: rotated constant changed its bit count");
      end
      if (use_imm && imm_rot == 4'd0) begin
         assert_imm_norot_carry_R2:
            assert (operand_out == 32'(imm_byte) && carry_out == carry_in)
            else $error("R2: unrotated constant or its carry wrong");
      end
      if (use_imm && imm_rot != 4'd0) begin
         assert_imm_rot_carry_R2:
            assert (carry_out == operand_out[MSB])
            else $error("R2: rotated constant carry not bit 31");
      end
      if (!use_imm && zero_cnt) begin
         assert_zero_count_pass_R5:
            assert (operand_out == src_value && carry_out == carry_in)
            else $error("R5: zero count did not pass through");
      end
      if (!use_imm && amt_from_reg && !shift_kind[1] && amt_reg[7:0] > 8'd32) begin
         assert_logical_over_R7:
            assert (operand_out == '0 && !carry_out)
            else $error("R7: logical shift past width not cleared");
      end
      if (!use_imm && amt_from_reg && shift_kind == 2'b10 && amt_reg[7:0] >= 8'd32) begin
         assert_arith_sat_R8:
            assert (operand_out == {DATA_W{src_value[MSB]}} && carry_out == src_value[MSB])
            else $error("R8: arithmetic shift past width not sign filled");
      end
      if (!use_imm && shift_kind == 2'b11) begin
         assert_rotate_keeps_bits_R9:
            assert ($countones(operand_out) == $countones(src_value))
            else $error("R9: rotate changed the bit count");
      end
   end

endmodule

bind opsh_operand_unit opsh_operand_chk #(.DATA_W(DATA_W)) i_opsh_chk (
   .use_imm      (use_imm),
   .imm_byte     (imm_byte),
   .imm_rot      (imm_rot),
   .shift_kind   (shift_kind),
   .amt_from_reg (amt_from_reg),
   .amt_field    (amt_field),
   .src_value    (src_value),
   .amt_reg      (amt_reg),
   .carry_in     (carry_in),
   .operand_out  (operand_out),
   .carry_out    (carry_out)
);

// File: tb/test_opsh_operand_unit.sv
module test_opsh_operand_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        use_imm, amt_from_reg, carry_in, carry_out;
   logic [7:0]  imm_byte;
   logic [3:0]  imm_rot;
   logic [1:0]  shift_kind;
   logic [4:0]  amt_field;
   logic [31:0] src_value, amt_reg, operand_out;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;   // 125 MHz

   opsh_operand_unit i_opsh_operand_unit (
      .use_imm      (use_imm),
      .imm_byte     (imm_byte),
      .imm_rot      (imm_rot),
      .shift_kind   (shift_kind),
      .amt_from_reg (amt_from_reg),
      .amt_field    (amt_field),
      .src_value    (src_value),
      .amt_reg      (amt_reg),
      .carry_in     (carry_in),
      .operand_out  (operand_out),
      .carry_out    (carry_out)
   );

   typedef struct packed {
      logic        ui;
      logic [7:0]  ib;
      logic [3:0]  ir;
      logic [1:0]  k;
      logic        fr;
      logic [4:0]  af;
      logic [31:0] sv;
      logic [31:0] ar;
      logic        ci;
      logic [31:0] eo;
      logic        ec;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 25;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 8'hFF, 4'h4, 2'd0, 1'b0, 5'd0,  32'h0,        32'h0,        1'b0, 32'hFF000000, 1'b1, 4'd1},  // R1
      '{1'b1, 8'h3F, 4'h1, 2'd0, 1'b0, 5'd0,  32'h0,        32'h0,        1'b0, 32'hC000000F, 1'b1, 4'd1},  // R1
      '{1'b1, 8'h81, 4'h0, 2'd0, 1'b0, 5'd0,  32'h0,        32'h0,        1'b1, 32'h00000081, 1'b1, 4'd2},  // R2
      '{1'b1, 8'h81, 4'h0, 2'd0, 1'b0, 5'd0,  32'h0,        32'h0,        1'b0, 32'h00000081, 1'b0, 4'd2},  // R2
      '{1'b1, 8'h01, 4'hF, 2'd0, 1'b0, 5'd0,  32'h0,        32'h0,        1'b1, 32'h00000004, 1'b0, 4'd2},  // R2
      '{1'b0, 8'h00, 4'h0, 2'd0, 1'b0, 5'd4,  32'h100000F1, 32'h0,        1'b0, 32'h00000F10, 1'b1, 4'd3},  // R3
      '{1'b0, 8'h00, 4'h0, 2'd1, 1'b0, 5'd1,  32'h00000003, 32'h0,        1'b0, 32'h00000001, 1'b1, 4'd3},  // R3
      '{1'b0, 8'h00, 4'h0, 2'd2, 1'b0, 5'd4,  32'h80000010, 32'h0,        1'b1, 32'hF8000001, 1'b0, 4'd3},  // R3
      '{1'b0, 8'h00, 4'h0, 2'd3, 1'b0, 5'd8,  32'h12345678, 32'h0,        1'b1, 32'h78123456, 1'b0, 4'd3},  // R3
      '{1'b0, 8'h00, 4'h0, 2'd0, 1'b0, 5'd31, 32'h00000003, 32'h0,        1'b0, 32'h80000000, 1'b1, 4'd4},  // R4
      '{1'b0, 8'h00, 4'h0, 2'd1, 1'b0, 5'd31, 32'h40000000, 32'h0,        1'b0, 32'h00000000, 1'b1, 4'd4},  // R4
      '{1'b0, 8'h00, 4'h0, 2'd2, 1'b0, 5'd0,  32'h80000000, 32'h0,        1'b0, 32'h80000000, 1'b0, 4'd5},  // R5
      '{1'b0, 8'h00, 4'h0, 2'd1, 1'b1, 5'd7,  32'hDEADBEEF, 32'hFFFFFF00, 1'b1, 32'hDEADBEEF, 1'b1, 4'd5},  // R5
      '{1'b0, 8'h00, 4'h0, 2'd0, 1'b1, 5'd9,  32'h000000FF, 32'h12345604, 1'b0, 32'h00000FF0, 1'b0, 4'd6},  // R6
      '{1'b0, 8'h00, 4'h0, 2'd0, 1'b1, 5'd3,  32'h00000001, 32'h00000020, 1'b0, 32'h00000000, 1'b1, 4'd7},  // R7
      '{1'b0, 8'h00, 4'h0, 2'd1, 1'b1, 5'd3,  32'h80000000, 32'h00000020, 1'b0, 32'h00000000, 1'b1, 4'd7},  // R7
      '{1'b0, 8'h00, 4'h0, 2'd0, 1'b1, 5'd3,  32'hFFFFFFFF, 32'h00000021, 1'b1, 32'h00000000, 1'b0, 4'd7},  // R7
      '{1'b0, 8'h00, 4'h0, 2'd1, 1'b1, 5'd3,  32'hFFFFFFFF, 32'h000000C8, 1'b1, 32'h00000000, 1'b0, 4'd7},  // R7
      '{1'b0, 8'h00, 4'h0, 2'd2, 1'b1, 5'd3,  32'h80000001, 32'h00000028, 1'b0, 32'hFFFFFFFF, 1'b1, 4'd8},  // R8
      '{1'b0, 8'h00, 4'h0, 2'd2, 1'b1, 5'd3,  32'h7FFFFFFF, 32'h00000020, 1'b1, 32'h00000000, 1'b0, 4'd8},  // R8
      '{1'b0, 8'h00, 4'h0, 2'd3, 1'b1, 5'd0,  32'h0000000F, 32'h00000024, 1'b0, 32'hF0000000, 1'b1, 4'd9},  // R9
      '{1'b0, 8'h00, 4'h0, 2'd3, 1'b1, 5'd0,  32'h80000001, 32'h00000040, 1'b0, 32'h80000001, 1'b1, 4'd9},  // R9
      '{1'b0, 8'h00, 4'h0, 2'd3, 1'b1, 5'd0,  32'h80000001, 32'h00000100, 1'b0, 32'h80000001, 1'b0, 4'd5},  // R5 vs R9
      '{1'b1, 8'h12, 4'h2, 2'd2, 1'b1, 5'd31, 32'hFFFFFFFF, 32'h00000001, 1'b0, 32'h20000001, 1'b0, 4'd10}, // R10
      '{1'b0, 8'hAB, 4'h7, 2'd1, 1'b0, 5'd4,  32'h000000F0, 32'h0,        1'b0, 32'h0000000F, 1'b0, 4'd10}  // R10
   };

   task automatic drive(input vec_t v);
      @(posedge clk);
      use_imm      = v.ui;
      imm_byte     = v.ib;
      imm_rot      = v.ir;
      shift_kind   = v.k;
      amt_from_reg = v.fr;
      amt_field    = v.af;
      src_value    = v.sv;
      amt_reg      = v.ar;
      carry_in     = v.ci;
   endtask

   task automatic judge(input string tag, input logic [31:0] eo, input logic ec);
      @(negedge clk);
      checks++;
      if (operand_out !== eo || carry_out !== ec) begin
         errors++;
         $display("FAIL %s: operand %h carry %b, expected operand %h carry %b",
                  tag, operand_out, carry_out, eo, ec);
      end
   endtask

   function automatic logic [31:0] rotr32(input logic [31:0] x, input int m);
      if (m == 0) return x;
      return (x >> m) | (x << (32 - m));
   endfunction

   initial begin
      #(8 * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      vec_t z;
      z = '0;
      drive(z);
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // Reset state: all inputs zero, register path, zero count (R5)
      judge("R5 reset-state", 32'h0, 1'b0);

      for (int i = 0; i < NV; i++) begin
         drive(VECS[i]);
         judge($sformatf("R%0d vector %0d", VECS[i].rq, i), VECS[i].eo, VECS[i].ec);
      end

      // R4: logical left sweep by instruction count
      for (int n = 1; n < 32; n++) begin
         vec_t v;
         logic [31:0] s;
         s = 32'hA5A5A5A5;
         v = '0;
         v.k = 2'd0; v.af = 5'(n); v.sv = s; v.ci = 1'b0;
         drive(v);
         judge($sformatf("R4 lsl sweep %0d", n), s << n, s[32 - n]);
      end

      // R9 and R5: rotate sweep by register count, carry_in opposite to bit 31
      for (int a = 0; a <= 70; a++) begin
         vec_t v;
         logic [31:0] s, e;
         logic        c;
         s = 32'h00008001;
         v = '0;
         v.k = 2'd3; v.fr = 1'b1; v.af = 5'd17; v.sv = s; v.ar = 32'(a); v.ci = 1'b1;
         e = rotr32(s, a % 32);
         c = (a == 0) ? 1'b1 : e[31];
         drive(v);
         judge($sformatf("R9 ror sweep %0d", a), e, c);
      end

      // R1 and R2: every rotate field on one constant
      for (int r = 0; r < 16; r++) begin
         vec_t v;
         logic [31:0] e;
         v = '0;
         v.ui = 1'b1; v.ib = 8'hC3; v.ir = 4'(r); v.ci = 1'b1; v.sv = 32'h5555AAAA;
         e = rotr32(32'h000000C3, 2 * r);
         drive(v);
         judge($sformatf("R1 imm sweep %0d", r), e, (r == 0) ? 1'b1 : e[31]);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule